// File: doc/BRIEF.md
# Serial Flash Status-Register Write Protection

This block holds the status register and the write-protect logic of a serial NOR flash device. It sits behind the serial front end, which has already assembled the incoming bytes. Its inputs are the chip-select framing, a strobe for each received byte, the byte itself, and the raw active-low write-protect pin. The block decodes the first byte of each frame as a command. It keeps three pieces of state: the write-enable latch, the status-write-disable bit and a quad-enable flag. It presents the status byte during a read-status frame. It then decides whether a write-status frame may change the register.

Protection has two modes. Hardware protection applies when the synchronised pin is low and the stored disable bit is set; a write-status command is then refused. Every other combination is software protection. In that mode a write-status command goes through provided the write-enable latch is set. An accepted command takes effect when chip select is released after the required data bytes. A refused command raises a one-cycle pulse on a sideband output.

Two parameters select variants. One makes write-status collect two data bytes, with the second byte carrying the quad-enable flag. The other makes the status byte report that flag.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset the status byte reads 0x00, with the write-enable latch, the disable bit and quad-enable all clear. The synchroniser flops reset to the pin-high, unprotected level.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch is reported in status bit 1.
- R3: Opcode 0x05 starts a read-status frame. From the cycle after the opcode byte until chip select drops, rsp_valid_o is 1 and rsp_o carries the status byte: bit 7 is the disable bit, bit 1 is the write-enable latch, and bits 5:2 and bit 0 are 0. At all other times rsp_valid_o is 0 and rsp_o is 0x00.
- R4: A write-status command (opcode 0x01) is refused when the write-enable latch is clear. The status byte does not change.
- R5: A write-status command is refused when the write-protect pin, after a two-flop synchroniser, is low at opcode decode and the disable bit is 1. The status byte, including the write-enable latch, does not change.
- R6: When a write-status command is accepted, the disable bit is loaded from bit 7 of the first data byte and the write-enable latch is cleared. Both changes happen at the chip-select release that follows the required data bytes. Data bytes beyond the required count are ignored.
- R7: A write-status frame that ends before the required data bytes arrive changes nothing, and the write-enable latch stays set.
- R8: With WRSR_BYTES=2, an accepted write-status command loads quad-enable from bit 1 of the second data byte. With QE_IN_STATUS=1, quad-enable appears in status bit 6; otherwise bit 6 reads 0.
- R9: reject_o is high for exactly one cycle, the cycle after a refused write-status opcode byte. It is never high for any other command or for an accepted write-status.
- R10: Opcodes other than the four above, and bytes strobed while chip select is low, have no effect. Only the first byte of a frame is decoded as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, high while a frame is in progress |
| byte_valid_i | input | 1 | One-cycle strobe for a received byte |
| byte_i | input | 8 | Received byte |
| wp_ni | input | 1 | Raw write-protect pin, active low, asynchronous |
| rsp_o | output | 8 | Status byte during a read-status frame, otherwise 0x00 |
| rsp_valid_o | output | 1 | High while rsp_o carries the status byte |
| reject_o | output | 1 | One-cycle pulse when a write-status command is refused |

## Verification
A wrong latch or disable bit stays hidden until the next read-status frame. It shows up in rsp_o in the cycle after that frame's opcode byte. A wrong protection decision shows up sooner, as reject_o in the cycle after the write-status opcode. If the decision is wrong the other way, the next read shows a status byte that should not have changed, or that should have. The bench therefore follows every frame with a read and checks reject_o after every opcode, both on the default build and on the two-byte, quad-reporting build.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;

  localparam int SRWD_POS   = 7;
  localparam int QE_POS     = 6;
  localparam int WEL_POS    = 1;
  localparam int QE_SRC_POS = 1;

  typedef enum logic [1:0] {
    ST_OPCODE,
    ST_READ,
    ST_COLLECT,
    ST_SKIP
  } sr_state_e;
endpackage

// File: rtl/flash_sr_wp_sync.sv
module flash_sr_wp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wp_ni,
  output logic wp_no
);
  logic [STAGES-1:0] q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[s] <= 1'b1;
        else         q[s] <= wp_ni;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[s] <= 1'b1;
        else         q[s] <= q[s-1];
      end
    end
  end

  assign wp_no = q[STAGES-1];
endmodule

// File: rtl/flash_sr_cmd_fsm.sv
module flash_sr_cmd_fsm
  import flash_sr_pkg::*;
#(
  parameter int NBYTES = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       wp_n_i,
  input  logic       wel_i,
  input  logic       srwd_i,
  output logic       set_wel_o,
  output logic       clr_wel_o,
  output logic       commit_o,
  output logic       new_srwd_o,
  output logic       new_qe_o,
  output logic       reading_o,
  output logic       reject_o
);
  localparam int CW = $clog2(NBYTES + 1);
  localparam logic [CW-1:0] FULL = CW'(NBYTES);

  sr_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic take, op_phase, wrsr_hit, blocked, reject_q, store;

  assign take     = cs_i && byte_valid_i;
  assign op_phase = take && (state_q == ST_OPCODE);
  assign wrsr_hit = op_phase && (byte_i == OP_WRSR);
  // hardware protection, or no write enable
  assign blocked  = !wel_i || (!wp_n_i && srwd_i);
  assign store    = take && (state_q == ST_COLLECT) && (cnt_q != FULL);

  assign set_wel_o = op_phase && (byte_i == OP_WREN);
  assign clr_wel_o = op_phase && (byte_i == OP_WRDI);
  assign commit_o  = !cs_i && (state_q == ST_COLLECT) && (cnt_q == FULL);
  assign reading_o = cs_i && (state_q == ST_READ);
  assign reject_o  = reject_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!cs_i) begin
      state_d = ST_OPCODE;
      cnt_d   = '0;
    end else if (take) begin
      unique case (state_q)
        ST_OPCODE: begin
          cnt_d = '0;
          if (byte_i == OP_RDSR)         state_d = ST_READ;
          else if (wrsr_hit && !blocked) state_d = ST_COLLECT;
          else                           state_d = ST_SKIP;
        end
        ST_COLLECT: if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_OPCODE;
      cnt_q    <= '0;
      reject_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      reject_q <= wrsr_hit && blocked;
    end
  end

  logic srwd_cap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     srwd_cap_q <= 1'b0;
    else if (store && cnt_q == '0)   srwd_cap_q <= byte_i[SRWD_POS];
  end
  assign new_srwd_o = srwd_cap_q;

  if (NBYTES >= 2) begin : g_qe_lane
    logic qe_cap_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          qe_cap_q <= 1'b0;
      else if (store && cnt_q == CW'(1))    qe_cap_q <= byte_i[QE_SRC_POS];
    end
    assign new_qe_o = qe_cap_q;
  end else begin : g_no_qe_lane
    assign new_qe_o = 1'b0;
  end
endmodule

// File: rtl/flash_sr_regs.sv
module flash_sr_regs
  import flash_sr_pkg::*;
#(
  parameter bit HAS_QE     = 1'b0,
  parameter bit QE_VISIBLE = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_wel_i,
  input  logic       clr_wel_i,
  input  logic       commit_i,
  input  logic       new_srwd_i,
  input  logic       new_qe_i,
  output logic       wel_o,
  output logic       srwd_o,
  output logic [7:0] status_o
);
  logic wel_q, srwd_q, qe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      srwd_q <= 1'b0;
      qe_q   <= 1'b0;
    end else begin
      if (commit_i) begin
        wel_q  <= 1'b0;
        srwd_q <= new_srwd_i;
        if (HAS_QE) qe_q <= new_qe_i;
      end else if (set_wel_i) begin
        wel_q <= 1'b1;
      end else if (clr_wel_i) begin
        wel_q <= 1'b0;
      end
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[SRWD_POS] = srwd_q;
    status_o[WEL_POS]  = wel_q;
    status_o[QE_POS]   = QE_VISIBLE ? qe_q : 1'b0;
  end

  assign wel_o  = wel_q;
  assign srwd_o = srwd_q;
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard #(
  parameter int WRSR_BYTES   = 1,
  parameter bit QE_IN_STATUS = 1'b0,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       wp_ni,
  output logic [7:0] rsp_o,
  output logic       rsp_valid_o,
  output logic       reject_o
);
  localparam bit HAS_QE = (WRSR_BYTES >= 2);

  logic wp_sync, wel, srwd, set_wel, clr_wel, commit, new_srwd, new_qe, reading;
  logic [7:0] status;

  flash_sr_wp_sync #(.STAGES(SYNC_STAGES)) u_wp_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wp_ni (wp_ni),
    .wp_no (wp_sync)
  );

  flash_sr_cmd_fsm #(.NBYTES(WRSR_BYTES)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_i        (cs_i),
    .byte_valid_i(byte_valid_i),
    .byte_i      (byte_i),
    .wp_n_i      (wp_sync),
    .wel_i       (wel),
    .srwd_i      (srwd),
    .set_wel_o   (set_wel),
    .clr_wel_o   (clr_wel),
    .commit_o    (commit),
    .new_srwd_o  (new_srwd),
    .new_qe_o    (new_qe),
    .reading_o   (reading),
    .reject_o    (reject_o)
  );

  flash_sr_regs #(.HAS_QE(HAS_QE), .QE_VISIBLE(QE_IN_STATUS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_wel_i (set_wel),
    .clr_wel_i (clr_wel),
    .commit_i  (commit),
    .new_srwd_i(new_srwd),
    .new_qe_i  (new_qe),
    .wel_o     (wel),
    .srwd_o    (srwd),
    .status_o  (status)
  );

  assign rsp_valid_o = reading;
  assign rsp_o       = reading ? status : 8'h00;
endmodule

// File: rtl/flash_sr_guard_chk.sv
module flash_sr_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_i,
  input logic [7:0] rsp_o,
  input logic       rsp_valid_o,
  input logic       reject_o,
  input logic       wel_i,
  input logic       srwd_i
);
  assert_reject_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |=> !reject_o);

  assert_srwd_at_cs_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srwd_i != $past(srwd_i)) |-> (!$past(cs_i) && $past(cs_i, 2)));

  assert_wel_cleared_on_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srwd_i != $past(srwd_i)) |-> !wel_i);

  assert_status_layout_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_o[5:2] == 4'h0 && !rsp_o[0] && rsp_o[1] == wel_i && rsp_o[7] == srwd_i));

  assert_idle_response_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_o == 8'h00));

  assert_refused_keeps_state_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |=> ($stable(wel_i) && $stable(srwd_i)));
endmodule

bind flash_sr_guard flash_sr_guard_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_i       (cs_i),
  .rsp_o      (rsp_o),
  .rsp_valid_o(rsp_valid_o),
  .reject_o   (reject_o),
  .wel_i      (wel),
  .srwd_i     (srwd)
);

// File: tb/flash_sr_guard_bench.sv
`timescale 1ns/1ps
module flash_sr_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, bv = 1'b0, wp_n = 1'b1;
  logic [7:0] bt = 8'h00;
  logic [7:0] rsp_a, rsp_b;
  logic rv_a, rv_b, rej_a, rej_b;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_sr_guard u_flash_sr_guard (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .byte_valid_i(bv), .byte_i(bt),
    .wp_ni(wp_n), .rsp_o(rsp_a), .rsp_valid_o(rv_a), .reject_o(rej_a));

  flash_sr_guard #(.WRSR_BYTES(2), .QE_IN_STATUS(1'b1)) u_flash_sr_guard_qe (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .byte_valid_i(bv), .byte_i(bt),
    .wp_ni(wp_n), .rsp_o(rsp_b), .rsp_valid_o(rv_b), .reject_o(rej_b));

  bit m_wel[2], m_srwd[2], m_qe[2];
  int need[2] = '{1, 2};
  bit qvis[2] = '{1'b0, 1'b1};

  function automatic logic [7:0] exp_st(int i);
    return {m_srwd[i], qvis[i] & m_qe[i], 4'b0000, m_wel[i], 1'b0};
  endfunction

  function automatic bit exp_rej(int i, logic [7:0] op);
    return (op == 8'h01) && (!m_wel[i] || (!wp_n && m_srwd[i]));
  endfunction

  task automatic chk(string tag, int inst, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s inst=%0d actual=%h expected=%h", tag, inst, act, exp);
    end
  endtask

  task automatic frame(logic [7:0] op, int nsent, logic [7:0] b0, logic [7:0] b1,
                       logic [7:0] b2, string tag);
    bit rj[2];
    logic [7:0] bytes[3];
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    for (int i = 0; i < 2; i++) rj[i] = exp_rej(i, op);
    @(negedge clk); cs = 1'b1; bv = 1'b1; bt = op;
    @(negedge clk); bv = 1'b0;
    for (int i = 0; i < 2; i++) begin
      chk(op != 8'h01 ? "R9" : (!m_wel[i] ? "R4" : "R5"), i,
          {7'd0, i == 0 ? rej_a : rej_b}, {7'd0, rj[i]});
      chk(op == 8'h05 ? "R3" : "R10", i, {7'd0, i == 0 ? rv_a : rv_b}, {7'd0, op == 8'h05});
      chk(op == 8'h05 ? (i == 0 ? tag : "R8") : "R3", i, i == 0 ? rsp_a : rsp_b,
          op == 8'h05 ? exp_st(i) : 8'h00);
    end
    @(negedge clk);
    chk("R9", 0, {7'd0, rej_a}, 8'h00);
    chk("R9", 1, {7'd0, rej_b}, 8'h00);
    for (int k = 0; k < nsent; k++) begin
      bt = bytes[k]; bv = 1'b1;
      @(negedge clk); bv = 1'b0;
      @(negedge clk);
    end
    cs = 1'b0;
    // stray byte while deselected: R10
    bv = 1'b1; bt = 8'h06;
    @(negedge clk); bv = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      if (op == 8'h06) m_wel[i] = 1'b1;
      else if (op == 8'h04) m_wel[i] = 1'b0;
      else if (op == 8'h01 && !rj[i] && nsent >= need[i]) begin
        m_srwd[i] = b0[7];
        if (need[i] == 2) m_qe[i] = b1[1];
        m_wel[i] = 1'b0;
      end
    end
  endtask

  task automatic rd(string tag);
    frame(8'h05, 1, 8'h00, 8'h00, 8'h00, tag);
  endtask

  task automatic set_wp(logic v);
    @(negedge clk); wp_n = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    wp_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 0, rsp_a, 8'h00);
    chk("R1", 1, {7'd0, rej_b}, 8'h00);
    rd("R1");
    // R4: write-status without write enable
    frame(8'h01, 2, 8'h80, 8'h02, 8'h00, "R4"); rd("R4");
    // R2: enable then disable
    frame(8'h06, 0, 0, 0, 0, "R2"); rd("R2");
    frame(8'h04, 0, 0, 0, 0, "R2"); rd("R2");
    // R6/R8: accepted write sets disable bit and quad-enable
    frame(8'h06, 0, 0, 0, 0, "R6");
    frame(8'h01, 3, 8'h80, 8'h02, 8'hFF, "R6"); rd("R6");
    // R5: hardware protection
    set_wp(1'b0);
    frame(8'h06, 0, 0, 0, 0, "R5");
    frame(8'h01, 2, 8'h00, 8'h00, 8'h00, "R5"); rd("R5");
    // pin high again: software mode, write allowed
    set_wp(1'b1);
    frame(8'h01, 2, 8'h00, 8'h02, 8'h00, "R6"); rd("R6");
    // pin low, disable bit clear: still software mode
    set_wp(1'b0);
    frame(8'h06, 0, 0, 0, 0, "R6");
    frame(8'h01, 2, 8'h80, 8'h00, 8'h00, "R6"); rd("R8");
    // R7: short frame
    set_wp(1'b1);
    frame(8'h06, 0, 0, 0, 0, "R7");
    frame(8'h01, 1, 8'h00, 8'h00, 8'h00, "R7"); rd("R7");
    frame(8'h06, 0, 0, 0, 0, "R7");
    frame(8'h01, 0, 8'h00, 8'h00, 8'h00, "R7"); rd("R7");
    // R10: unknown opcode with trailing bytes that look like commands
    frame(8'h9F, 3, 8'h06, 8'h01, 8'h80, "R10"); rd("R10");
    // random mix
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 300; n++) begin
      logic [7:0] op;
      int sel = $urandom % 6;
      case (sel)
        0: op = 8'h06;
        1: op = 8'h04;
        2, 3: op = 8'h01;
        4: op = 8'h05;
        default: op = 8'($urandom);
      endcase
      if (($urandom % 4) == 0) set_wp(1'($urandom));
      frame(op, $urandom % 4, 8'($urandom), 8'($urandom), 8'($urandom), "R6");
      rd("R6");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule